// File: doc/BRIEF.md
# Multi-Size Transform Block Issue Scheduler

This block hands executable transform blocks of one coding tree unit to pools of fixed-latency processors, with a separate pool for each block size (4x4, 8x8, 16x16, 32x32). A companion dependency tracker supplies four ready maps, with one bit per Z-order position for each size. The current quad-tree split supplies four partition masks of the same shapes. A position can be started when its ready bit and its mask bit are both set and it has not yet been started in this unit. The scheduler starts such positions as soon as a processor of the matching size is free.

Every start is reported in the same cycle as a one-cycle pulse in an output map of the same shape. The set bit's index is the Z-order position, and the map it appears in gives the size, so the tracker can set its completion state. Each processor is a busy counter that holds the size's latency. A processor can accept new work in the last cycle of its current job, so back-to-back blocks of one size start exactly one latency apart. A completion flag rises when every masked position has been started and every processor has gone idle. A start pulse clears the record of started positions before the next unit.

Top module: `tu_issue_sched`

## Requirements
- R1: After reset no start pulse is produced while ready inputs are low. The completion flag is high when all masks are zero and low when any mask bit is set.
- R2: A position is started only when its ready bit and its mask bit are both 1. A ready bit with a clear mask bit, or a mask bit with a clear ready bit, never produces a start.
- R3: When more candidates of one size exist than there are free processors, the ones with the lowest Z-order bit indices are started first.
- R4: The start decision is combinational in the cycle where a candidate and a free processor coincide. A processor started in cycle c is busy for the size's latency (default 7, 22, 82 and 322 cycles for 4x4 up to 32x32). It accepts its next block in cycle c+latency.
- R5: Each position is started at most once per unit, even while its ready bit stays high.
- R6: Up to the pool size of starts can occur per size per cycle (default two for 4x4, one for each other size). The four sizes start independently in the same cycle.
- R7: A start appears as bit i of the start map of its size for exactly one cycle, where i is the Z-order index. The 4x4 map is 256 bits, the 8x8 map is 64, the 16x16 map is 16 and the 32x32 map is 4.
- R8: The completion flag is high exactly when every masked position has been started and every processor counter is zero. That is latency+1 cycles after the last start.
- R9: In a cycle where the unit-start input is high, nothing is started and the started-position record is cleared. A position started earlier can be started again afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctu_start | input | 1 | Clears the started-position record; blocks starts in its cycle |
| rdy_4 | input | 256 | Ready map, 4x4 positions in Z-order |
| rdy_8 | input | 64 | Ready map, 8x8 positions |
| rdy_16 | input | 16 | Ready map, 16x16 positions |
| rdy_32 | input | 4 | Ready map, 32x32 positions |
| msk_4 | input | 256 | Partition mask, 4x4 |
| msk_8 | input | 64 | Partition mask, 8x8 |
| msk_16 | input | 16 | Partition mask, 16x16 |
| msk_32 | input | 4 | Partition mask, 32x32 |
| mark_4 | output | 256 | Start pulses, 4x4 |
| mark_8 | output | 64 | Start pulses, 8x8 |
| mark_16 | output | 16 | Start pulses, 16x16 |
| mark_32 | output | 4 | Start pulses, 32x32 |
| ctu_done | output | 1 | All masked positions started and all processors idle |

## Verification
Two functions can fall in the same cycle: a processor running its last busy cycle, and a new block of the same size being started on it. The bench holds a pending 4x4 and a pending 8x8 candidate ready while their pools are fully occupied. It requires each start pulse to appear exactly in cycle c+7 and c+22 and in no cycle before. A 32x32 pair is checked the same way at c+322. The unit-start input meeting a live ready bit is also provoked: no pulse is allowed in that cycle, and the same position must start in the following cycle.

// File: rtl/tu_issue_pkg.sv
package tu_issue_pkg;
   localparam int NUM_SIZES  = 4;
   localparam int TOTAL_BITS = 340;

   // bits of the map for size index s (0 = 4x4 ... 3 = 32x32)
   function automatic int map_bits(input int s);
      return 1 << (2 * (NUM_SIZES - s));
   endfunction

   // offset of size s inside the flattened map vector
   function automatic int map_off(input int s);
      int acc;
      acc = 0;
      for (int k = 0; k < s; k++) acc += map_bits(k);
      return acc;
   endfunction
endpackage

// File: rtl/tu_busy_ctr.sv
module tu_busy_ctr #(
   parameter int LAT = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic free,
   output logic idle
);
   localparam int CW = $clog2(LAT + 1);

   if (LAT < 1) begin : g_bad_lat
      $error("tu_busy_ctr: LAT must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (load)       cnt_q <= CW'(LAT);
      else if (cnt_q != 0) cnt_q <= cnt_q - CW'(1);
   end

   // free during the final busy cycle so the next job starts back to back
   assign free = (cnt_q <= CW'(1));
   assign idle = (cnt_q == '0);

   a_r4_load_full : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == CW'(LAT)));
   a_r4_count_down : assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q > CW'(1)) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/tu_issue_pool.sv
module tu_issue_pool #(
   parameter int NBITS = 16,
   parameter int NPROC = 1,
   parameter int LAT   = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [NBITS-1:0] rdy,
   input  logic [NBITS-1:0] msk,
   output logic [NBITS-1:0] mark,
   output logic             pend,
   output logic             idle
);
   if (NBITS < 1 || NPROC < 1) begin : g_bad_cfg
      $error("tu_issue_pool: NBITS and NPROC must be at least 1");
   end

   logic [NBITS-1:0] issued_q;
   logic [NBITS-1:0] cand;
   logic [NBITS-1:0] rem;
   logic [NPROC-1:0] free;
   logic [NPROC-1:0] idle_p;
   logic [NPROC-1:0] grant;

   // hand the lowest remaining Z-order candidate to each free processor
   always_comb begin
      cand  = rdy & msk & ~issued_q;
      rem   = cand;
      grant = '0;
      for (int p = 0; p < NPROC; p++) begin
         if (!clr && free[p] && (rem != '0)) begin
            grant[p] = 1'b1;
            rem      = rem & (rem - NBITS'(1));
         end
      end
      mark = clr ? '0 : (cand & ~rem);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   issued_q <= '0;
      else if (clr) issued_q <= '0;
      else          issued_q <= issued_q | mark;
   end

   for (genvar p = 0; p < NPROC; p++) begin : g_proc
      tu_busy_ctr #(.LAT(LAT)) u_ctr (
         .clk  (clk),
         .rst_n(rst_n),
         .load (grant[p]),
         .free (free[p]),
         .idle (idle_p[p])
      );
   end

   assign pend = |(msk & ~issued_q);
   assign idle = &idle_p;

   a_r2_needs_both : assert property (@(posedge clk) disable iff (!rst_n)
      ((mark & ~(rdy & msk)) == '0));
   a_r5_no_reissue : assert property (@(posedge clk) disable iff (!rst_n)
      ((mark & issued_q) == '0));
   a_r6_pool_bound : assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(mark) <= $countones(free)));
   a_r7_recorded : assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && mark != '0) |=> ((issued_q & $past(mark)) == $past(mark)));
endmodule

// File: rtl/tu_issue_sched.sv
module tu_issue_sched
   import tu_issue_pkg::*;
#(
   parameter int N4  = 2,
   parameter int N8  = 1,
   parameter int N16 = 1,
   parameter int N32 = 1,
   parameter int L4  = 7,
   parameter int L8  = 22,
   parameter int L16 = 82,
   parameter int L32 = 322
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ctu_start,
   input  logic [255:0] rdy_4,
   input  logic [63:0]  rdy_8,
   input  logic [15:0]  rdy_16,
   input  logic [3:0]   rdy_32,
   input  logic [255:0] msk_4,
   input  logic [63:0]  msk_8,
   input  logic [15:0]  msk_16,
   input  logic [3:0]   msk_32,
   output logic [255:0] mark_4,
   output logic [63:0]  mark_8,
   output logic [15:0]  mark_16,
   output logic [3:0]   mark_32,
   output logic         ctu_done
);
   localparam int NP_A [NUM_SIZES] = '{N4, N8, N16, N32};
   localparam int LT_A [NUM_SIZES] = '{L4, L8, L16, L32};

   if (N4 < 1 || N8 < 1 || N16 < 1 || N32 < 1) begin : g_bad_np
      $error("tu_issue_sched: every pool needs at least one processor");
   end
   if (L4 < 1 || L8 < 1 || L16 < 1 || L32 < 1) begin : g_bad_lat
      $error("tu_issue_sched: every latency must be at least 1");
   end

   logic [TOTAL_BITS-1:0] rdy_all, msk_all, mark_all;
   logic [NUM_SIZES-1:0]  pend_s, idle_s;

   assign rdy_all = {rdy_32, rdy_16, rdy_8, rdy_4};
   assign msk_all = {msk_32, msk_16, msk_8, msk_4};

   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
      localparam int W = map_bits(s);
      localparam int O = map_off(s);
      tu_issue_pool #(.NBITS(W), .NPROC(NP_A[s]), .LAT(LT_A[s])) u_pool (
         .clk  (clk),
         .rst_n(rst_n),
         .clr  (ctu_start),
         .rdy  (rdy_all[O +: W]),
         .msk  (msk_all[O +: W]),
         .mark (mark_all[O +: W]),
         .pend (pend_s[s]),
         .idle (idle_s[s])
      );
   end

   assign mark_4   = mark_all[map_off(0) +: 256];
   assign mark_8   = mark_all[map_off(1) +: 64];
   assign mark_16  = mark_all[map_off(2) +: 16];
   assign mark_32  = mark_all[map_off(3) +: 4];
   assign ctu_done = ~|pend_s & &idle_s;

   a_r8_done_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      ctu_done |-> (mark_all == '0));
   a_r9_start_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      ctu_start |-> (mark_all == '0));
endmodule

// File: tb/tu_issue_sched_test.sv
`timescale 1ns/1ps
module tu_issue_sched_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ctu_start = 1'b0;
   logic [255:0] rdy_4 = '0, msk_4 = '0;
   logic [63:0]  rdy_8 = '0, msk_8 = '0;
   logic [15:0]  rdy_16 = '0, msk_16 = '0;
   logic [3:0]   rdy_32 = '0, msk_32 = '0;
   logic [255:0] mark_4;
   logic [63:0]  mark_8;
   logic [15:0]  mark_16;
   logic [3:0]   mark_32;
   logic         ctu_done;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   tu_issue_sched uut (
      .clk(clk), .rst_n(rst_n), .ctu_start(ctu_start),
      .rdy_4(rdy_4), .rdy_8(rdy_8), .rdy_16(rdy_16), .rdy_32(rdy_32),
      .msk_4(msk_4), .msk_8(msk_8), .msk_16(msk_16), .msk_32(msk_32),
      .mark_4(mark_4), .mark_8(mark_8), .mark_16(mark_16), .mark_32(mark_32),
      .ctu_done(ctu_done)
   );

   // rdy4, msk4, exp4 (16 bits each), rdy8, msk8, exp8 (8 bits each)
   localparam logic [71:0] VEC [6] = '{
      {16'hFFFF, 16'h0001, 16'h0001, 8'h00, 8'h00, 8'h00},
      {16'h00F0, 16'hFFFF, 16'h0030, 8'h00, 8'h00, 8'h00},
      {16'h8001, 16'h8000, 16'h8000, 8'h00, 8'h00, 8'h00},
      {16'h0000, 16'h0000, 16'h0000, 8'h0C, 8'h0E, 8'h04},
      {16'h0A00, 16'h0E00, 16'h0A00, 8'h01, 8'h01, 8'h01},
      {16'h0000, 16'hFFFF, 16'h0000, 8'hFF, 8'h00, 8'h00}
   };

   task automatic check(input bit ok, input string req,
                        input logic [255:0] act, input logic [255:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_marks(input string req, input logic [255:0] e4,
                              input logic [63:0] e8, input logic [3:0] e32);
      check(mark_4 == e4, {req, " mark_4"}, mark_4, e4);
      check(mark_8 == e8, {req, " mark_8"}, 256'(mark_8), 256'(e8));
      check(mark_16 == '0, {req, " mark_16"}, 256'(mark_16), 256'(0));
      check(mark_32 == e32, {req, " mark_32"}, 256'(mark_32), 256'(e32));
   endtask

   task automatic clear_inputs();
      rdy_4 = '0; rdy_8 = '0; rdy_16 = '0; rdy_32 = '0;
      msk_4 = '0; msk_8 = '0; msk_16 = '0; msk_32 = '0;
   endtask

   task automatic idle_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 200000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1: reset state
      idle_cycles(3);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check_marks("R1", '0, '0, '0);
      check(ctu_done == 1'b1, "R1 done empty masks", 256'(ctu_done), 256'(1));
      msk_4[0] = 1'b1;
      #1;
      check(ctu_done == 1'b0, "R1 done with mask", 256'(ctu_done), 256'(0));

      // vector table: R2 R3 R6 R7, start cycle quiet per R9
      for (int v = 0; v < 6; v++) begin
         @(negedge clk);
         clear_inputs();
         ctu_start = 1'b1;
         msk_4[15:0] = VEC[v][55:40];
         msk_8[7:0]  = VEC[v][15:8];
         rdy_4[15:0] = VEC[v][71:56];
         rdy_8[7:0]  = VEC[v][23:16];
         #1;
         check_marks("R9 start cycle", '0, '0, '0);
         @(negedge clk);
         ctu_start = 1'b0;
         #1;
         check_marks($sformatf("R2/R3/R6 vector %0d", v),
                     256'(VEC[v][39:24]), 64'(VEC[v][7:0]), '0);
         @(negedge clk);
         clear_inputs();
         idle_cycles(25);
      end

      // R4 R5 R8: occupancy, same-cycle reissue, completion timing
      @(negedge clk);
      clear_inputs();
      ctu_start = 1'b1;
      msk_4[2:0] = 3'b111;
      msk_8[1:0] = 2'b11;
      @(negedge clk);
      ctu_start = 1'b0;
      rdy_4[2:0] = 3'b111;
      rdy_8[1:0] = 2'b11;
      for (int k = 0; k <= 46; k++) begin
         logic [255:0] e4;
         logic [63:0]  e8;
         if (k > 0) @(negedge clk);
         #1;
         e4 = (k == 0) ? 256'h3 : (k == 7) ? 256'h4 : 256'h0;
         e8 = (k == 0) ? 64'h1 : (k == 22) ? 64'h2 : 64'h0;
         check_marks($sformatf("R4/R5 cycle %0d", k), e4, e8, '0);
         if (k == 44)
            check(ctu_done == 1'b0, "R8 done early", 256'(ctu_done), 256'(0));
         if (k == 45)
            check(ctu_done == 1'b1, "R8 done", 256'(ctu_done), 256'(1));
      end

      // R9: record cleared, no start in the start cycle
      @(negedge clk);
      clear_inputs();
      ctu_start = 1'b1;
      msk_4[0] = 1'b1;
      rdy_4[0] = 1'b1;
      #1;
      check_marks("R9 blocked", '0, '0, '0);
      @(negedge clk);
      ctu_start = 1'b0;
      #1;
      check_marks("R9 restart", 256'h1, '0, '0);
      @(negedge clk);
      clear_inputs();
      idle_cycles(10);

      // R4 at the largest size: next 32x32 start 322 cycles later
      @(negedge clk);
      ctu_start = 1'b1;
      msk_32 = 4'b0011;
      @(negedge clk);
      ctu_start = 1'b0;
      rdy_32 = 4'b0011;
      #1;
      check_marks("R4 32x32 first", '0, '0, 4'h1);
      for (int k = 1; k <= 323; k++) begin
         @(negedge clk); #1;
         if (k == 321 || k == 322 || k == 323)
            check_marks($sformatf("R4 32x32 cycle %0d", k), '0, '0,
                        (k == 322) ? 4'h2 : 4'h0);
         else if (mark_32 != '0)
            check(1'b0, "R4 32x32 early", 256'(mark_32), 256'(0));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule